// File: doc/BRIEF.md
# Interval Timer and Event Counter with Self-Arming Interrupt Mask

This block is a small peripheral for a 4-bit controller core and runs on the instruction-rate clock. A free-running 6-bit prescaler divides that clock by 64. A 4-bit up-counter steps on each prescaler overflow in timer mode, or on each rising edge of an external pin in event mode. The core can load the counter, read it, pick the count source, and set, clear or read a single interrupt mask flag.

When the counter rolls over from its top value to zero, it keeps counting. If the mask flag was clear at that moment, the block raises a sticky interrupt request and sets the mask flag, so later rollovers stay silent until software clears the mask again. Loading the counter also restarts the prescaler, so the first timer step comes exactly one full prescaler period after the load.

Top module: `tick_timer4`

## Requirements
- R1: A synchronous active-high reset clears the counter, the prescaler, the source flag, the mask flag, the interrupt request and the wrap pulse to 0.
- R2: In timer mode (source flag 0) the counter steps by one 64 clocks after the prescaler was last cleared, and again every 64 clocks after that.
- R3: When load_en is high, count_q takes load_val at the next edge and the prescaler restarts from zero. A load wins over an increment in the same cycle.
- R4: In event mode (source flag 1) each rising edge on ext_pin steps the counter exactly once, three clocks after the pin rises (two synchronizer stages plus the edge detector). A level held high gives no further steps.
- R5: A step from the top count value gives 0, and counting continues from there (…14, 15, 0, 1…). wrap_q is high for one cycle after each rollover.
- R6: A rollover while mask_q is 0 sets irq_req and sets mask_q in the same edge.
- R7: A rollover while mask_q is 1 leaves irq_req unchanged and mask_q at 1.
- R8: cmd value 1 sets mask_q and cmd value 2 clears it. mask_q is readable as an output. A mask command in the same cycle as a rollover is applied after the rollover's automatic set.
- R9: irq_req stays high until a cycle with irq_ack high clears it. A new request in the same cycle as irq_ack wins.
- R10: cmd value 3 selects timer mode (src_q = 0) and cmd value 4 selects event mode (src_q = 1). In event mode, prescaler overflows do not step the counter. cmd value 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Flag command: 0 none, 1 mask set, 2 mask clear, 3 timer mode, 4 event mode |
| load_en | input | 1 | Load the counter and restart the prescaler |
| load_val | input | CNT_W | Value to load |
| ext_pin | input | 1 | Asynchronous external count input |
| irq_ack | input | 1 | Clears the pending interrupt request |
| count_q | output | CNT_W | Current counter value |
| src_q | output | 1 | Count source flag (0 timer, 1 event) |
| mask_q | output | 1 | Interrupt mask flag |
| irq_req | output | 1 | Sticky interrupt request |
| wrap_q | output | 1 | One-cycle pulse after a rollover |

## Verification
The bench builds the block with its default parameters: a 6-bit prescaler, a 4-bit counter and two synchronizer stages. With these values the 64-clock prescaler period can be checked on both sides of its boundary, and a rollover is reached by loading 14 or 15 and giving one or two pin edges. Because the wrap can be placed in a chosen cycle, the same-cycle orderings can be driven on purpose: a load against a prescaler step, a mask clear against the automatic set, and an acknowledge against a new request.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_MASK_SET  = 3'd1,
    CMD_MASK_CLR  = 3'd2,
    CMD_SRC_TIMER = 3'd3,
    CMD_SRC_EVENT = 3'd4
  } tick_cmd_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // The last state before the divider folds back to zero: the next edge is edge 2**PRE_W.
  assign tick = &div_q;
endmodule

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count + 1'b1;
  end

  assign wrap = step & ~load & (&count);
endmodule

// File: rtl/tick_timer4.sv
module tick_timer4
  import tick_pkg::*;
#(
  parameter int PRE_W       = 6,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ext_pin,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] count_q,
  output logic             src_q,
  output logic             mask_q,
  output logic             irq_req,
  output logic             wrap_q
);
  logic pre_tick;
  logic ext_rise;
  logic step;
  logic wrap_evt;
  logic mask_d;

  tick_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(load_en), .tick(pre_tick)
  );

  tick_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .rise(ext_rise)
  );

  assign step = src_q ? ext_rise : pre_tick;

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_en), .load_val(load_val),
    .step(step), .count(count_q), .wrap(wrap_evt)
  );

  // The rollover sets the mask first; an explicit command then overrides it.
  always_comb begin
    mask_d = mask_q;
    if (wrap_evt)                  mask_d = 1'b1;
    if (cmd == CMD_MASK_SET)       mask_d = 1'b1;
    else if (cmd == CMD_MASK_CLR)  mask_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= 1'b0;
      mask_q  <= 1'b0;
      irq_req <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= wrap_evt;
      mask_q <= mask_d;
      if (cmd == CMD_SRC_TIMER)      src_q <= 1'b0;
      else if (cmd == CMD_SRC_EVENT) src_q <= 1'b1;
      if (wrap_evt && !mask_q) irq_req <= 1'b1;
      else if (irq_ack)        irq_req <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_timer4_chk.sv
module tick_timer4_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic [CNT_W-1:0] load_val,
  input logic             irq_ack,
  input logic [CNT_W-1:0] count_q,
  input logic             mask_q,
  input logic             irq_req,
  input logic             wrap_q
);
  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> count_q == $past(load_val));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> (count_q == $past(count_q)) ||
                 (count_q == CNT_W'($past(count_q) + 1'b1)));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> count_q == '0);

  // R6
  unmasked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_q && !$past(mask_q)) |-> irq_req);

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> !$past(mask_q));

  // R9
  sticky_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> irq_req);
endmodule

bind tick_timer4 tick_timer4_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
  .irq_ack(irq_ack), .count_q(count_q), .mask_q(mask_q),
  .irq_req(irq_req), .wrap_q(wrap_q)
);

// File: tb/tick_timer4_bench.sv
module tick_timer4_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic       load_en = 1'b0;
  logic [3:0] load_val = 4'd0;
  logic       ext_pin = 1'b0;
  logic       irq_ack = 1'b0;
  logic [3:0] count_q;
  logic       src_q, mask_q, irq_req, wrap_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  tick_timer4 u_tick_timer4 (
    .clk(clk), .rst(rst), .cmd(cmd), .load_en(load_en), .load_val(load_val),
    .ext_pin(ext_pin), .irq_ack(irq_ack), .count_q(count_q), .src_q(src_q),
    .mask_q(mask_q), .irq_req(irq_req), .wrap_q(wrap_q)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int v);
    load_en = 1'b1; load_val = 4'(v);
    tick(1);
    load_en = 1'b0;
  endtask

  task automatic issue(input int c);
    cmd = 3'(c);
    tick(1);
    cmd = 3'd0;
  endtask

  task automatic pulse();
    ext_pin = 1'b1;
    tick(2);
    ext_pin = 1'b0;
    tick(3);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    chk("R1 count", count_q, 0);
    chk("R1 mask", mask_q, 0);
    chk("R1 src", src_q, 0);
    chk("R1 irq", irq_req, 0);
  endtask

  task automatic t_timer();
    load(5);
    chk("R3 load", count_q, 5);
    tick(63);
    chk("R2 before period", count_q, 5);
    tick(1);
    chk("R2 at period", count_q, 6);
    tick(63);
    load_en = 1'b1; load_val = 4'd9;
    tick(1);
    load_en = 1'b0;
    chk("R3 load beats step", count_q, 9);
    tick(63);
    chk("R3 prescaler restart early", count_q, 9);
    tick(1);
    chk("R3 prescaler restart", count_q, 10);
  endtask

  task automatic t_event();
    issue(4);
    chk("R10 event mode", src_q, 1);
    load(3);
    tick(70);
    chk("R10 timer ignored", count_q, 3);
    pulse();
    chk("R4 one edge", count_q, 4);
    ext_pin = 1'b1;
    tick(10);
    ext_pin = 1'b0;
    tick(3);
    chk("R4 held level", count_q, 5);
  endtask

  task automatic t_wrap();
    load(14);
    pulse();
    chk("R6 no early irq", irq_req, 0);
    pulse();
    chk("R5 rollover", count_q, 0);
    chk("R6 irq raised", irq_req, 1);
    chk("R6 mask armed", mask_q, 1);
    pulse();
    chk("R5 continues", count_q, 1);
    chk("R9 sticky", irq_req, 1);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    chk("R9 ack clears", irq_req, 0);
  endtask

  task automatic t_masked();
    load(15);
    pulse();
    chk("R7 wrap count", count_q, 0);
    chk("R7 no irq", irq_req, 0);
    chk("R7 mask kept", mask_q, 1);
  endtask

  task automatic t_cmds();
    issue(2);
    chk("R8 clear", mask_q, 0);
    issue(1);
    chk("R8 set", mask_q, 1);
    issue(2);
    chk("R8 clear again", mask_q, 0);
    load(15);
    ext_pin = 1'b1;
    tick(2);
    cmd = 3'd2; irq_ack = 1'b1;
    tick(1);
    cmd = 3'd0; irq_ack = 1'b0; ext_pin = 1'b0;
    chk("R8 same-cycle count", count_q, 0);
    chk("R8 command after auto set", mask_q, 0);
    chk("R9 set beats ack", irq_req, 1);
    issue(0);
    chk("R10 no-op keeps src", src_q, 1);
    issue(3);
    chk("R10 timer mode", src_q, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(1);
    t_reset();
    t_timer();
    t_event();
    t_wrap();
    t_masked();
    t_cmds();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule